// File: doc/BRIEF.md
# Three-Level Hierarchical Motion Search Controller

This block steers the motion search for one 16x16 macroblock. It does not touch pixels. It issues candidate displacements on a request handshake. A separate matching engine scores each one and returns a matching error on a response handshake. The block keeps the best candidates and moves through three resolution levels, coarsest first and finest last. At the end it reports the winning motion vector together with that vector's error.

At the coarsest level the block scans a full grid on a picture decimated 4:1 per axis, and two survivors leave that level. The middle level works at 2:1 decimation. It runs three 3x3 local searches: one around each survivor and one around a predictor vector taken from an already coded neighbouring macroblock. Only the single best point goes forward. The finest level first searches the 3x3 integer-pel neighbourhood of that point. It then searches the half-pel ring around the best integer point.

In split mode the finest level runs once for each 8x8 sub-block, so four vectors come out. Every displacement is saturated to the legal half-pel range. A point already scored in the same search stage is not requested again.

Top module: `ms_search_ctrl`

## Requirements
- R1: A search runs its levels in a fixed order: coarsest, then middle, then finest. `req_level` is 0, 1 and 2 for these levels, and within one search it never decreases.
- R2: The coarsest level requests 81 points. Each axis takes the values 8*k half-pels for k = -4..+4, and +32 saturates to +31. `req_dy` is the outer loop and `req_dx` the inner loop, both ascending.
- R3: The coarsest level keeps the two lowest-error points. Among equal errors the earlier-requested point ranks higher.
- R4: The middle level searches three centres in this order: the coarsest-level best, the coarsest-level second, and the predictor latched at start. Around each centre it visits offsets -4, 0, +4 half-pels per axis, with dy outer and dx inner.
- R5: Exactly one point leaves the middle level. It is the lowest-error point over all three local searches, and on a tie the earlier one wins.
- R6: For each sub-block the finest level visits offsets -2, 0, +2 around the middle-level point. It then visits offsets -1, 0, +1 around the best point found so far at that level. In both passes dy is the outer loop and dx the inner loop.
- R7: The reported vector is the lowest-error point of the finest level, with ties kept by the earlier point. `mv_err` is its error. Each result comes with a one-cycle `done` pulse.
- R8: Every requested component is saturated to the range -32..+31 half-pels (-16.0 to +15.5 pels).
- R9: Within the middle level, and within one sub-block's finest-level search, a displacement that was already requested is skipped and not issued again.
- R10: When `split_en` is high at start, the finest level runs four times with `req_blk` set to 0, 1, 2 and 3 in turn. This produces four `done` pulses with `mv_blk` set to 0..3. Otherwise a single result is produced with `mv_blk` = 0.
- R11: A request stays stable until it is accepted, and at most one request is outstanding at a time. `rsp_ready` is high only while a response is awaited.
- R12: After reset the block is idle, with no request, no `done` and `busy` low. A `start` pulse while busy is ignored, and `pred_x`, `pred_y` and `split_en` are sampled only when a search starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (accepted when idle) |
| split_en | input | 1 | Select four 8x8 sub-block results |
| pred_x | input | 6 | Spatial predictor x, signed half-pels |
| pred_y | input | 6 | Spatial predictor y, signed half-pels |
| req_valid | output | 1 | Candidate request valid |
| req_ready | input | 1 | Matching engine accepts the request |
| req_level | output | 2 | Resolution level of the request |
| req_blk | output | 2 | Sub-block index of the request |
| req_dx | output | 6 | Candidate x, signed half-pels |
| req_dy | output | 6 | Candidate y, signed half-pels |
| rsp_valid | input | 1 | Matching error valid |
| rsp_ready | output | 1 | Block awaits a matching error |
| rsp_err | input | ERR_W (16) | Matching error of the outstanding request |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result pulse |
| mv_blk | output | 2 | Sub-block index of the result |
| mv_x | output | 6 | Result x, signed half-pels |
| mv_y | output | 6 | Result y, signed half-pels |
| mv_err | output | ERR_W (16) | Matching error of the result |

## Verification
Two events can land in the same cycle: a point is skipped as a repeat, and the level or sub-block hands over. That happens when the last point of a 3x3 window was already scored. The bench provokes it in two ways. First, it places the predictor on top of a coarse survivor. Second, it drives the cost minimum to the saturated corners, where clamped half-pel neighbours fold onto integer points. The full request stream, in order and including the first point after each hand-over, is compared against a bench model that walks the same search with its own loops and its own list of visited points. Any skipped or extra point appears there as a miscompare.

// File: rtl/ms_pkg.sv
package ms_pkg;
  localparam int HP_W    = 6;
  localparam int HP_MIN  = -(1 << (HP_W - 1));
  localparam int HP_MAX  = (1 << (HP_W - 1)) - 1;
  localparam int DEC_C   = 4;            // coarse decimation per axis
  localparam int DEC_M   = 2;            // middle decimation per axis
  localparam int STEP_C  = 2 * DEC_C;    // coarse grid pitch in half-pels
  localparam int STEP_M  = 2 * DEC_M;    // middle window pitch in half-pels
  localparam int STEP_FI = 2;            // integer-pel pitch
  localparam int STEP_FH = 1;            // half-pel pitch
  localparam int LOC_N   = 3;            // local window side
  localparam int MID_CEN = 3;            // centres at the middle level

  typedef logic signed [HP_W-1:0] hp_t;
  typedef struct packed { hp_t x; hp_t y; } mv_t;

  typedef enum logic [1:0] {PH_COARSE = 2'd0, PH_MID = 2'd1,
                            PH_FINT = 2'd2, PH_FHALF = 2'd3} phase_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_STEP} state_e;

  // saturate an integer displacement into the legal half-pel range
  function automatic hp_t sat_hp(input int v);
    if (v < HP_MIN) return hp_t'(HP_MIN);
    if (v > HP_MAX) return hp_t'(HP_MAX);
    return hp_t'(v);
  endfunction

  // point idx of an n-wide window of given pitch around base
  function automatic hp_t win_pt(input int idx, input int n, input int pitch, input hp_t base);
    return sat_hp(int'(base) + pitch * (idx - (n - 1) / 2));
  endfunction

  function automatic int pitch_of(input phase_e p);
    case (p)
      PH_COARSE: return STEP_C;
      PH_MID:    return STEP_M;
      PH_FINT:   return STEP_FI;
      default:   return STEP_FH;
    endcase
  endfunction

  function automatic logic [1:0] level_of(input phase_e p);
    case (p)
      PH_COARSE: return 2'd0;
      PH_MID:    return 2'd1;
      default:   return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/ms_pointgen.sv
module ms_pointgen import ms_pkg::*; #(
  parameter int COARSE_R = 4,
  parameter int CW       = 4
) (
  input  phase_e         ph,
  input  logic [CW-1:0]  ox,
  input  logic [CW-1:0]  oy,
  input  mv_t            centre,
  output mv_t            pt
);
  localparam int COARSE_N = 2 * COARSE_R + 1;

  always_comb begin
    if (ph == PH_COARSE) begin
      pt.x = win_pt(int'(ox), COARSE_N, STEP_C, '0);
      pt.y = win_pt(int'(oy), COARSE_N, STEP_C, '0);
    end else begin
      pt.x = win_pt(int'(ox), LOC_N, pitch_of(ph), centre.x);
      pt.y = win_pt(int'(oy), LOC_N, pitch_of(ph), centre.y);
    end
  end
endmodule

// File: rtl/ms_seen_list.sv
module ms_seen_list import ms_pkg::*; #(
  parameter int DEPTH = 27
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  add,
  input  mv_t   add_pt,
  input  mv_t   q_pt,
  output logic  hit
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  mv_t              ent [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [DEPTH-1:0] match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign match[g] = (CNT_W'(g) < cnt) && (ent[g] == q_pt);
    always_ff @(posedge clk) begin
      if (add && !clr && cnt == CNT_W'(g)) ent[g] <= add_pt;
    end
  end

  assign hit = |match;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (add) cnt <= cnt + 1'b1;
  end

  // R9
  list_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add && !clr |-> cnt < CNT_W'(DEPTH));
  // R9
  list_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add && !clr |-> !hit || q_pt != add_pt);
endmodule

// File: rtl/ms_rank.sv
module ms_rank import ms_pkg::*; #(
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  mv_t              ld_pt,
  input  logic [ERR_W-1:0] ld_err,
  output mv_t              b1_pt,
  output logic [ERR_W-1:0] b1_err,
  output mv_t              b2_pt
);
  logic             ok1, ok2;
  logic [ERR_W-1:0] e2;
  logic             beats1, beats2;

  // strict compare keeps the earlier point on a tie
  assign beats1 = !ok1 || (ld_err < b1_err);
  assign beats2 = !ok2 || (ld_err < e2);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      ok1 <= 1'b0; ok2 <= 1'b0;
      b1_pt <= '0; b2_pt <= '0; b1_err <= '0; e2 <= '0;
    end else if (load) begin
      if (beats1) begin
        b2_pt <= b1_pt; e2 <= b1_err; ok2 <= ok1;
        b1_pt <= ld_pt; b1_err <= ld_err; ok1 <= 1'b1;
      end else if (beats2) begin
        b2_pt <= ld_pt; e2 <= ld_err; ok2 <= 1'b1;
      end
    end
  end

  // R3
  rank_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok1 && ok2 |-> b1_err <= e2);
  // R5
  rank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok1 && load && !clr && ld_err >= b1_err |=> $stable(b1_pt));
endmodule

// File: rtl/ms_search_ctrl.sv
module ms_search_ctrl import ms_pkg::*; #(
  parameter int ERR_W    = 16,
  parameter int COARSE_R = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   split_en,
  input  logic signed [HP_W-1:0] pred_x,
  input  logic signed [HP_W-1:0] pred_y,
  output logic                   req_valid,
  input  logic                   req_ready,
  output logic [1:0]             req_level,
  output logic [1:0]             req_blk,
  output logic signed [HP_W-1:0] req_dx,
  output logic signed [HP_W-1:0] req_dy,
  input  logic                   rsp_valid,
  output logic                   rsp_ready,
  input  logic [ERR_W-1:0]       rsp_err,
  output logic                   busy,
  output logic                   done,
  output logic [1:0]             mv_blk,
  output logic signed [HP_W-1:0] mv_x,
  output logic signed [HP_W-1:0] mv_y,
  output logic [ERR_W-1:0]       mv_err
);
  localparam int COARSE_N = 2 * COARSE_R + 1;
  localparam int CW       = $clog2(COARSE_N);
  localparam int DEPTH    = MID_CEN * LOC_N * LOC_N;
  localparam logic [CW-1:0] LIM_C = CW'(COARSE_N - 1);
  localparam logic [CW-1:0] LIM_L = CW'(LOC_N - 1);

  state_e          st;
  phase_e          ph;
  logic [CW-1:0]   ox, oy;
  logic [1:0]      cen, blk;
  logic            split_q;
  mv_t             c0, c1, pv, mc, fc;
  mv_t             centre, cur;
  mv_t             b1_pt, b2_pt;
  logic [ERR_W-1:0] b1_err;

  // named internal events
  logic hit, dup, req_fire, rsp_fire, step_now, start_go;
  logic x_last, y_last, lvl_last, blk_last, stage_clr;
  logic [CW-1:0] lim;

  always_comb begin
    case (ph)
      PH_MID:   centre = (cen == 2'd0) ? c0 : (cen == 2'd1) ? c1 : pv;
      PH_FINT:  centre = mc;
      PH_FHALF: centre = fc;
      default:  centre = '0;
    endcase
  end

  ms_pointgen #(.COARSE_R(COARSE_R), .CW(CW)) u_pointgen (
    .ph(ph), .ox(ox), .oy(oy), .centre(centre), .pt(cur)
  );

  assign start_go  = (st == ST_IDLE) && start;
  assign dup       = (ph != PH_COARSE) && hit;
  assign req_valid = (st == ST_ISSUE) && !dup;
  assign rsp_ready = (st == ST_WAIT);
  assign req_fire  = req_valid && req_ready;
  assign rsp_fire  = rsp_valid && rsp_ready;
  assign step_now  = ((st == ST_ISSUE) && dup) || (st == ST_STEP);
  assign lim       = (ph == PH_COARSE) ? LIM_C : LIM_L;
  assign x_last    = (ox == lim);
  assign y_last    = (oy == lim);
  assign lvl_last  = x_last && y_last && (ph != PH_MID || cen == 2'd2);
  assign blk_last  = !split_q || blk == 2'd3;
  // a search stage ends: new level, or a new sub-block
  assign stage_clr = start_go || (step_now && lvl_last && ph != PH_FINT);

  ms_seen_list #(.DEPTH(DEPTH)) u_seen (
    .clk(clk), .rst_n(rst_n), .clr(stage_clr),
    .add(req_fire && ph != PH_COARSE), .add_pt(cur), .q_pt(cur), .hit(hit)
  );

  ms_rank #(.ERR_W(ERR_W)) u_rank (
    .clk(clk), .rst_n(rst_n), .clr(stage_clr), .load(rsp_fire),
    .ld_pt(cur), .ld_err(rsp_err), .b1_pt(b1_pt), .b1_err(b1_err), .b2_pt(b2_pt)
  );

  assign req_dx    = cur.x;
  assign req_dy    = cur.y;
  assign req_level = level_of(ph);
  assign req_blk   = blk;
  assign busy      = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= PH_COARSE;
      ox <= '0; oy <= '0; cen <= '0; blk <= '0; split_q <= 1'b0;
      c0 <= '0; c1 <= '0; pv <= '0; mc <= '0; fc <= '0;
      done <= 1'b0; mv_blk <= '0; mv_x <= '0; mv_y <= '0; mv_err <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          pv <= '{x: pred_x, y: pred_y};
          split_q <= split_en;
          ph <= PH_COARSE; ox <= '0; oy <= '0; cen <= '0; blk <= '0;
          st <= ST_ISSUE;
        end
        ST_ISSUE: if (req_fire) st <= ST_WAIT;
        ST_WAIT:  if (rsp_fire) st <= ST_STEP;
        default: ;
      endcase
      if (step_now) begin
        st <= ST_ISSUE;
        if (!x_last) begin
          ox <= ox + 1'b1;
        end else if (!y_last) begin
          ox <= '0; oy <= oy + 1'b1;
        end else begin
          ox <= '0; oy <= '0;
          case (ph)
            PH_COARSE: begin
              c0 <= b1_pt; c1 <= b2_pt; cen <= '0; ph <= PH_MID;
            end
            PH_MID: begin
              if (cen != 2'd2) cen <= cen + 1'b1;
              else begin mc <= b1_pt; ph <= PH_FINT; end
            end
            PH_FINT: begin
              fc <= b1_pt; ph <= PH_FHALF;
            end
            default: begin
              done <= 1'b1; mv_blk <= blk;
              mv_x <= b1_pt.x; mv_y <= b1_pt.y; mv_err <= b1_err;
              ph <= PH_FINT;
              if (blk_last) st <= ST_IDLE;
              else blk <= blk + 1'b1;
            end
          endcase
        end
      end
    end
  end

  // ---------------- assertions ----------------
  logic [1:0] last_lvl;
  always_ff @(posedge clk) begin
    if (!rst_n || start_go) last_lvl <= 2'd0;
    else if (req_fire)      last_lvl <= req_level;
  end

  // R1
  level_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_level >= last_lvl);
  // R2
  coarse_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_level == 2'd0 |->
      ((int'(req_dx) % STEP_C) == 0 || int'(req_dx) == HP_MAX) &&
      ((int'(req_dy) % STEP_C) == 0 || int'(req_dy) == HP_MAX));
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_dx) && $stable(req_dy)
      && $stable(req_level) && $stable(req_blk));
  // R11
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_valid && rsp_ready);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid && !rsp_ready);
  // R10
  blk_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_blk != 2'd0 |-> split_q && req_level == 2'd2);
endmodule

// File: tb/test_ms_search_ctrl.sv
module test_ms_search_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ERR_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, split_en = 1'b0;
  logic signed [5:0] pred_x = '0, pred_y = '0;
  logic req_valid, req_ready, rsp_valid, rsp_ready, busy, done;
  logic [1:0] req_level, req_blk, mv_blk;
  logic signed [5:0] req_dx, req_dy, mv_x, mv_y;
  logic [ERR_W-1:0] rsp_err, mv_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  ms_search_ctrl #(.ERR_W(ERR_W), .COARSE_R(4)) i_ms_search_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .split_en(split_en),
    .pred_x(pred_x), .pred_y(pred_y), .req_valid(req_valid), .req_ready(req_ready),
    .req_level(req_level), .req_blk(req_blk), .req_dx(req_dx), .req_dy(req_dy),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err), .busy(busy),
    .done(done), .mv_blk(mv_blk), .mv_x(mv_x), .mv_y(mv_y), .mv_err(mv_err)
  );

  int n_chk = 0, n_fail = 0;
  int tx[4], ty[4];
  int wgt = 1, nsd = 0;
  bit flat = 1'b0;
  bit cur_split = 1'b0;
  logic [15:0] exp_req[$];
  logic [29:0] exp_done[$];
  int sxa[32], sya[32], sn;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int absi(input int v); return (v < 0) ? -v : v; endfunction
  function automatic int sat(input int v);
    return (v < -32) ? -32 : (v > 31) ? 31 : v;
  endfunction
  function automatic int cost(input int lvl, input int b, input int x, input int y);
    if (flat) return 100;
    return (absi(x - tx[b]) + absi(y - ty[b])) * wgt + ((x * 37 + y * 91 + lvl * 13 + b * 7 + nsd) & 3);
  endfunction
  function automatic bit seen_has(input int x, input int y);
    for (int i = 0; i < sn; i++) if (sxa[i] == x && sya[i] == y) return 1'b1;
    return 1'b0;
  endfunction

  // visit one local window; returns updated best through refs
  task automatic visit(input int lvl, input int b, input int cx, input int cy, input int p,
                       inout int bx, inout int by, inout int be, inout bit ok);
    for (int j = -1; j <= 1; j++)
      for (int i = -1; i <= 1; i++) begin
        int x = sat(cx + p * i);
        int y = sat(cy + p * j);
        int e;
        if (!seen_has(x, y)) begin
          sxa[sn] = x; sya[sn] = y; sn++;
          exp_req.push_back({2'(lvl), 2'(b), 6'(x), 6'(y)});
          e = cost(lvl, b, x, y);
          if (!ok || e < be) begin bx = x; by = y; be = e; ok = 1'b1; end
        end
      end
  endtask

  task automatic build_model(input int px, input int py, input bit sp);
    int ax = 0, ay = 0, ae = 0, bx2 = 0, by2 = 0, be2 = 0;
    bit ok1 = 0, ok2 = 0;
    int mx = 0, my = 0, me = 0; bit okm = 0;
    int cxs[3], cys[3];
    for (int gy = -4; gy <= 4; gy++)
      for (int gx = -4; gx <= 4; gx++) begin
        int x = sat(8 * gx), y = sat(8 * gy), e;
        exp_req.push_back({2'd0, 2'd0, 6'(x), 6'(y)});
        e = cost(0, 0, x, y);
        if (!ok1 || e < ae) begin
          bx2 = ax; by2 = ay; be2 = ae; ok2 = ok1; ax = x; ay = y; ae = e; ok1 = 1;
        end else if (!ok2 || e < be2) begin
          bx2 = x; by2 = y; be2 = e; ok2 = 1;
        end
      end
    cxs[0] = ax; cys[0] = ay; cxs[1] = bx2; cys[1] = by2; cxs[2] = px; cys[2] = py;
    sn = 0;
    for (int c = 0; c < 3; c++) visit(1, 0, cxs[c], cys[c], 4, mx, my, me, okm);
    for (int b = 0; b < (sp ? 4 : 1); b++) begin
      int fx = 0, fy = 0, fe = 0; bit okf = 0;
      sn = 0;
      visit(2, b, mx, my, 2, fx, fy, fe, okf);
      visit(2, b, fx, fy, 1, fx, fy, fe, okf);
      exp_done.push_back({2'(b), 6'(fx), 6'(fy), 16'(fe)});
    end
  endtask

  // matching-engine model: random ready and response latency
  initial begin
    logic [15:0] got, want;
    bit pend = 0;
    logic [15:0] pend_v = '0;
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_err = '0;
    forever begin
      @(negedge clk);
      got = {req_level, req_blk, req_dx, req_dy};
      if (pend) begin
        // R11 request held while not accepted
        check(req_valid && got == pend_v, "R11 hold", {15'd0, req_valid, got}, {16'd1, pend_v});
        pend = 0;
      end
      if (req_valid && ($urandom % 3 != 0)) begin
        req_ready = 1'b1;
        want = (exp_req.size() > 0) ? exp_req.pop_front() : 16'hFFFF;
        case (got[15:14])
          2'd0:    check(got == want, "R2/R8 coarse req", {16'd0, got}, {16'd0, want});
          2'd1:    check(got == want, "R4/R3/R1 middle req", {16'd0, got}, {16'd0, want});
          default: check(got == want, "R6/R5/R9/R8 fine req", {16'd0, got}, {16'd0, want});
        endcase
        @(negedge clk);
        req_ready = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
        rsp_valid = 1'b1;
        rsp_err = ERR_W'(cost(int'(got[15:14]), int'(got[13:12]),
                              int'($signed(got[11:6])), int'($signed(got[5:0]))));
        @(negedge clk);
        rsp_valid = 1'b0;
      end else begin
        req_ready = 1'b0;
        if (req_valid) begin pend = 1; pend_v = got; end
      end
    end
  end

  // result monitor
  initial begin
    logic [29:0] g, w;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        g = {mv_blk, mv_x, mv_y, mv_err};
        w = (exp_done.size() > 0) ? exp_done.pop_front() : '1;
        if (cur_split) check(g == w, "R10 split result", {2'd0, g}, {2'd0, w});
        else           check(g == w, "R7 result", {2'd0, g}, {2'd0, w});
      end
    end
  end

  task automatic run_case(input int px, input int py, input bit sp, input int poke);
    cur_split = sp;
    build_model(px, py, sp);
    @(negedge clk);
    start = 1'b1; split_en = sp; pred_x = 6'(px); pred_y = 6'(py);
    @(negedge clk);
    start = 1'b0; split_en = !sp; pred_x = 6'(px + 9); pred_y = 6'(py - 5);
    if (poke > 0) begin
      // R12 start while busy must not restart or re-sample
      repeat (poke) @(negedge clk);
      start = 1'b1; split_en = !sp;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    check(exp_req.size() == 0, "R9 request count", 32'(exp_req.size()), 32'd0);
    check(exp_done.size() == 0, sp ? "R10 result count" : "R7 result count",
          32'(exp_done.size()), 32'd0);
    exp_req.delete(); exp_done.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!busy && !req_valid && !done && !rsp_ready, "R12 reset",
          {28'd0, busy, req_valid, done, rsp_ready}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy, "R12 idle after reset", {31'd0, busy}, 32'd0);

    // flat cost: every tie goes to the first point
    flat = 1; run_case(5, -3, 0, 0);
    flat = 0; wgt = 3; nsd = 1;
    for (int b = 0; b < 4; b++) begin tx[b] = 31; ty[b] = 31 - b; end
    run_case(31, 31, 1, 40);                 // R8 upper clamp, predictor duplicates
    for (int b = 0; b < 4; b++) begin tx[b] = -32 + b; ty[b] = -32; end
    run_case(-32, -32, 1, 0);                // R8 lower clamp
    for (int b = 0; b < 4; b++) begin tx[b] = 8; ty[b] = -16; end
    wgt = 4; run_case(8, -16, 0, 120);       // predictor on a coarse survivor
    for (int n = 0; n < 12; n++) begin
      wgt = 1 + int'($urandom % 4); nsd = int'($urandom % 4);
      for (int b = 0; b < 4; b++) begin
        tx[b] = int'($urandom % 64) - 32; ty[b] = int'($urandom % 64) - 32;
      end
      run_case(int'($urandom % 64) - 32, int'($urandom % 64) - 32,
               bit'($urandom % 2), int'($urandom % 200));
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule